// File: doc/BRIEF.md
# Column Ones Counter (2 to 7 inputs)

This block counts how many of its same-weight input bits are 1 and returns that count as a small binary number. It is meant for the reduction tree of a parallel multiplier. A column of partial-product bits that share one weight collapses into a weight-1 bit (`sum_o`), a weight-2 bit (`cout1_o`) and a weight-4 bit (`cout2_o`). The parameter `M` sets the column height and selects the counter for it. Heights 2 and 3 are the half-adder and full-adder cases. Heights 4 to 7 each get a dedicated structure.

None of the counters contains a behavioural adder. Each is built from pairwise propagate terms (XOR of two bits), generate terms (AND of two bits) and 3:2 full-adder cells. The height-4 counter works directly from two propagate/generate pairs. The height-5 counter adds the fifth bit through its AND cross terms with the other four. The height-6 counter reduces three propagate/generate pairs with two 3:2 cells and one half adder. The height-7 counter uses four 3:2 cells arranged in two levels. The block is purely combinational and holds no state.

Top module: `col_count`

## Requirements
- R1: For every input pattern and every M from 2 to 7, sum_o + 2*cout1_o + 4*cout2_o equals the number of 1 bits on bits_i.
- R2: sum_o equals the XOR of all M input bits.
- R3: cout2_o is 1 only when at least four inputs are 1, and it is always 0 for M of 2 or 3.
- R4: With M=4 and all inputs 1, the outputs are cout2_o=1, cout1_o=0, sum_o=0.
- R5: With M=7 and all inputs 1, all three outputs are 1.
- R6: An all-zero input gives all-zero outputs for every M.
- R7: With M=5, bit 4 alone gives only sum_o=1, and bit 4 with any two of bits 0 to 3 gives cout1_o=1 and sum_o=1.
- R8: With M=6, three 1 bits spread one per pair (bits 0, 2, 4) give cout1_o=1 and sum_o=1, and all six bits give cout2_o=1 and cout1_o=1.
- R9: M=2 behaves as a half adder (sum_o, cout1_o) and M=3 behaves as a full adder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_i | input | M | Same-weight column bits to be counted |
| sum_o | output | 1 | Count bit of weight 1 |
| cout1_o | output | 1 | Count bit of weight 2 |
| cout2_o | output | 1 | Count bit of weight 4 |

## Verification
Every height is driven through all of its input patterns and compared with a popcount. This catches a missing or doubled carry term, for example a height-6 counter that loses the carry when one pair generates and two pairs propagate. Directed cases cover the patterns where carries collide. Four ones in a 4-input column must give only the weight-4 bit, and a design that ORs the generate terms instead of XORing them would also raise cout1_o. For the 5-input counter the fifth bit meets an odd number of other ones, and a broken cross-term carry would report a count two too low. For the 7-input counter the all-ones column drives the top 3:2 cell with three carries at once.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef logic [2:0] cnt_t; // {weight4, weight2, weight1}

  function automatic int cnt_val(cnt_t v);
    return 4 * int'(v[2]) + 2 * int'(v[1]) + int'(v[0]);
  endfunction
endpackage

// File: rtl/ha_cell.sv
module ha_cell (
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i;
  assign co_o = a_i & b_i;
endmodule

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  logic p;
  assign p    = a_i ^ b_i;
  assign s_o  = p ^ c_i;
  assign co_o = (a_i & b_i) | (p & c_i);

  always_comb begin
    // R1
    fa_value_chk: assert (2 * int'(co_o) + int'(s_o) == int'(a_i) + int'(b_i) + int'(c_i))
      else $error("fa_cell value mismatch");
  end
endmodule

// File: rtl/col_counter.sv
module col_counter
  import cnt_pkg::*;
#(
  parameter int M = 7
) (
  input  logic [M-1:0] x_i,
  output cnt_t         cnt_o
);
  generate
    if (M == 2) begin : g_m2
      logic s, c;
      ha_cell u_ha (.a_i(x_i[0]), .b_i(x_i[1]), .s_o(s), .co_o(c));
      assign cnt_o = {1'b0, c, s};
    end else if (M == 3) begin : g_m3
      logic s, c;
      fa_cell u_fa (.a_i(x_i[0]), .b_i(x_i[1]), .c_i(x_i[2]), .s_o(s), .co_o(c));
      assign cnt_o = {1'b0, c, s};
    end else if (M == 4) begin : g_m4
      logic p0, p1, g0, g1;
      assign p0 = x_i[0] ^ x_i[1];
      assign p1 = x_i[2] ^ x_i[3];
      assign g0 = x_i[0] & x_i[1];
      assign g1 = x_i[2] & x_i[3];
      assign cnt_o = {g0 & g1, (p0 & p1) | (g0 ^ g1), p0 ^ p1};
    end else if (M == 5) begin : g_m5
      logic p0, p1, g0, g1, h0, h1, h2, h3;
      logic c1_lo, c2_lo, k;
      assign p0 = x_i[0] ^ x_i[1];
      assign p1 = x_i[2] ^ x_i[3];
      assign g0 = x_i[0] & x_i[1];
      assign g1 = x_i[2] & x_i[3];
      // cross terms of the fifth bit with the first four
      assign h0 = x_i[0] & x_i[4];
      assign h1 = x_i[1] & x_i[4];
      assign h2 = x_i[2] & x_i[4];
      assign h3 = x_i[3] & x_i[4];
      assign c1_lo = (p0 & p1) | (g0 ^ g1);
      assign c2_lo = g0 & g1;
      assign k     = (h0 ^ h1) ^ (h2 ^ h3); // carry out of weight 1
      assign cnt_o = {c2_lo | (c1_lo & k), c1_lo ^ k, p0 ^ p1 ^ x_i[4]};
    end else if (M == 6) begin : g_m6
      logic [2:0] p, g;
      logic ps, pc, gs, gc, ms, mc;
      for (genvar j = 0; j < 3; j++) begin : g_pair
        assign p[j] = x_i[2*j] ^ x_i[2*j+1];
        assign g[j] = x_i[2*j] & x_i[2*j+1];
      end
      fa_cell u_fp (.a_i(p[0]), .b_i(p[1]), .c_i(p[2]), .s_o(ps), .co_o(pc));
      fa_cell u_fg (.a_i(g[0]), .b_i(g[1]), .c_i(g[2]), .s_o(gs), .co_o(gc));
      ha_cell u_hm (.a_i(pc), .b_i(gs), .s_o(ms), .co_o(mc));
      // gc and mc never rise together: at most three pairs exist
      assign cnt_o = {gc | mc, ms, ps};
    end else begin : g_m7
      logic sa, ca, sb, cb, sc, cc, sd, cd;
      fa_cell u_fa (.a_i(x_i[0]), .b_i(x_i[1]), .c_i(x_i[2]), .s_o(sa), .co_o(ca));
      fa_cell u_fb (.a_i(x_i[3]), .b_i(x_i[4]), .c_i(x_i[5]), .s_o(sb), .co_o(cb));
      fa_cell u_fc (.a_i(sa), .b_i(sb), .c_i(x_i[M-1]), .s_o(sc), .co_o(cc));
      fa_cell u_fd (.a_i(ca), .b_i(cb), .c_i(cc), .s_o(sd), .co_o(cd));
      assign cnt_o = {cd, sd, sc};
    end
  endgenerate

  always_comb begin
    if (!$isunknown(x_i)) begin
      // R1
      cnt_match_chk: assert (cnt_val(cnt_o) == $countones(x_i))
        else $error("count mismatch");
      // R2
      sum_parity_chk: assert (cnt_o[0] == ^x_i)
        else $error("parity mismatch");
      // R3
      c2_min_chk: assert (!cnt_o[2] || $countones(x_i) >= 4)
        else $error("weight-4 bit with fewer than four ones");
    end
  end
endmodule

// File: rtl/col_count.sv
module col_count
  import cnt_pkg::*;
#(
  parameter int M = 7
) (
  input  logic [M-1:0] bits_i,
  output logic         sum_o,
  output logic         cout1_o,
  output logic         cout2_o
);
  cnt_t cnt;

  col_counter #(.M(M)) u_cnt (.x_i(bits_i), .cnt_o(cnt));

  assign sum_o   = cnt[0];
  assign cout1_o = cnt[1];
  assign cout2_o = cnt[2];

  always_comb begin
    // R3
    c2_small_chk: assert (M > 3 || !cout2_o)
      else $error("weight-4 bit on a short column");
  end
endmodule

// File: tb/tb_col_count.sv
module tb_col_count;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [6:0] in7 = '0;
  logic [5:0] in6 = '0;
  logic [4:0] in5 = '0;
  logic [3:0] in4 = '0;
  logic [2:0] in3 = '0;
  logic [1:0] in2 = '0;
  logic [2:0] o7, o6, o5, o4, o3, o2;

  col_count #(.M(7)) dut  (.bits_i(in7), .sum_o(o7[0]), .cout1_o(o7[1]), .cout2_o(o7[2]));
  col_count #(.M(6)) dut6 (.bits_i(in6), .sum_o(o6[0]), .cout1_o(o6[1]), .cout2_o(o6[2]));
  col_count #(.M(5)) dut5 (.bits_i(in5), .sum_o(o5[0]), .cout1_o(o5[1]), .cout2_o(o5[2]));
  col_count #(.M(4)) dut4 (.bits_i(in4), .sum_o(o4[0]), .cout1_o(o4[1]), .cout2_o(o4[2]));
  col_count #(.M(3)) dut3 (.bits_i(in3), .sum_o(o3[0]), .cout1_o(o3[1]), .cout2_o(o3[2]));
  col_count #(.M(2)) dut2 (.bits_i(in2), .sum_o(o2[0]), .cout1_o(o2[1]), .cout2_o(o2[2]));

  function automatic int ones(logic [6:0] v, int m);
    int n = 0;
    for (int i = 0; i < m; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic check(string req, int m, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s M=%0d got=%b expected=%b", req, m, got, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  // R6
  task automatic t_zero();
    in7 = '0; in6 = '0; in5 = '0; in4 = '0; in3 = '0; in2 = '0;
    settle();
    check("R6", 7, o7, 3'b000); check("R6", 6, o6, 3'b000);
    check("R6", 5, o5, 3'b000); check("R6", 4, o4, 3'b000);
    check("R6", 3, o3, 3'b000); check("R6", 2, o2, 3'b000);
  endtask

  // R1 R2 R3 R9: every pattern for every height
  task automatic t_exhaustive();
    for (int p = 0; p < 128; p++) begin
      logic [6:0] v;
      v = 7'(p);
      in7 = v; in6 = v[5:0]; in5 = v[4:0]; in4 = v[3:0]; in3 = v[2:0]; in2 = v[1:0];
      settle();
      check("R1", 7, o7, 3'(ones(v, 7)));
      if (p < 64) check("R1", 6, o6, 3'(ones(v, 6)));
      if (p < 32) check("R1", 5, o5, 3'(ones(v, 5)));
      if (p < 16) check("R1", 4, o4, 3'(ones(v, 4)));
      if (p < 8)  check("R9", 3, o3, 3'(ones(v, 3)));
      if (p < 4)  check("R9", 2, o2, 3'(ones(v, 2)));
      check("R2", 7, {2'b00, o7[0]}, {2'b00, ^v});
      if (p < 8) check("R3", 3, {2'b00, o3[2]}, 3'b000);
      if (p < 4) check("R3", 2, {2'b00, o2[2]}, 3'b000);
    end
  endtask

  // R4
  task automatic t_four_full();
    in4 = 4'b1111;
    settle();
    check("R4", 4, o4, 3'b100);
  endtask

  // R5
  task automatic t_seven_full();
    in7 = 7'h7f;
    settle();
    check("R5", 7, o7, 3'b111);
  endtask

  // R7
  task automatic t_five_cross();
    in5 = 5'b10000; settle(); check("R7", 5, o5, 3'b001);
    in5 = 5'b10011; settle(); check("R7", 5, o5, 3'b011);
    in5 = 5'b11010; settle(); check("R7", 5, o5, 3'b011);
    in5 = 5'b11111; settle(); check("R7", 5, o5, 3'b101);
  endtask

  // R8
  task automatic t_six_pairs();
    in6 = 6'b010101; settle(); check("R8", 6, o6, 3'b011);
    in6 = 6'b111111; settle(); check("R8", 6, o6, 3'b110);
    in6 = 6'b110101; settle(); check("R8", 6, o6, 3'b100);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    t_zero();
    t_exhaustive();
    t_four_full();
    t_seven_full();
    t_five_cross();
    t_six_pairs();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule